// File: doc/BRIEF.md
# Three-Wire Serial Register Write Port

This block takes control words from a three-wire serial link made of a serial clock, a data line and a latch strobe. It turns them into register writes for a control register bank in the system clock domain. The three serial lines are oversampled by the system clock through multi-stage synchronizers, and their edges are detected after synchronization. Each rising edge of the serial clock shifts one data bit into a 16-bit shift register, most significant bit first. A rising edge of the latch strobe commits whatever the shift register holds at that moment.

A commit produces a single-cycle write pulse, together with a 7-bit register address taken from the upper bits of the word and 9 bits of register data taken from the lower bits. A mode input turns the port off when the two-wire control mode is selected. While the port is off, its shift register is held clear and it issues no writes.

Top module: `ser3_write_port`

## Requirements
- R1: A committed 16-bit word is split so that word bits 15..9 appear on `wr_addr` and word bits 8..0 appear on `wr_data`. The first bit shifted in is the most significant bit.
- R2: Exactly one data bit, the value of `ser_dat`, is shifted in per rising edge of `ser_clk`. Falling edges of `ser_clk` shift nothing.
- R3: Each rising edge of `ser_latch` while `mode_3w` is 1 produces exactly one `wr_valid` pulse lasting one system clock cycle.
- R4: When more than 16 bits are shifted before a latch, only the most recent 16 bits are committed. Older bits are dropped.
- R5: When fewer than 16 bits are shifted after a clear, the committed word holds those bits in its least significant positions and zeros above them.
- R6: A falling edge of `ser_latch`, or `ser_latch` held high while bits are shifted, produces no `wr_valid` pulse.
- R7: While `mode_3w` is 0, no `wr_valid` pulse is issued and the shift register is cleared. Bits shifted before the port was turned off never reach a later write.
- R8: Synchronous active-high reset `rst` clears `wr_valid`, `wr_addr`, `wr_data` and the shift register.
- R9: `wr_addr` and `wr_data` hold their values between write pulses, even while new bits are being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| mode_3w | input | 1 | 1 enables the three-wire port; 0 means two-wire mode is selected and the port is off |
| ser_clk | input | 1 | Serial clock, asynchronous to `clk` |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_latch | input | 1 | Latch strobe; its rising edge commits a word |
| wr_valid | output | 1 | One-cycle write pulse |
| wr_addr | output | 7 | Register address of the last committed word |
| wr_data | output | 9 | Register data of the last committed word |

## Verification
The assertions assume that each level of the serial lines lasts at least a few system clock cycles. That lets the synchronizers settle and lets every edge be seen exactly once. They also assume that `ser_dat` is stable around each serial clock rising edge. The stimulus holds every serial phase for four system clock cycles and changes data only while `ser_clk` is low. It never raises `ser_latch` in the same phase as a `ser_clk` rising edge, so a commit never races a shift.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 9;
  localparam int WORD_W = ADDR_W + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctrl_word_t;
endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/ser3_edge.sv
module ser3_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= level;
  end

  assign rise = level & ~prev;

  AST_RISE_NOT_TWICE: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((rise & $past(rise)) == '0)); // R2
endmodule

// File: rtl/ser3_shift.sv
module ser3_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !en) sh <= '0;
    else if (step)  sh <= {sh[WORD_W-2:0], bit_in};
  end

  assign word = sh;

  AST_SHIFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !en |=> (word == '0)); // R7
  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (rst)
    (en && step) |=> (word[0] == $past(bit_in))); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !step) |=> $stable(word)); // R2
endmodule

// File: rtl/ser3_write_port.sv
module ser3_write_port
  import ser3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_3w,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_latch,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int NSIG = 3;
  localparam int I_CLK = 0;
  localparam int I_DAT = 1;
  localparam int I_LAT = 2;

  logic [NSIG-1:0] raw_in, sync_in;
  logic [1:0]      rises;
  logic [WORD_W-1:0] word;
  ctrl_word_t        cw;

  assign raw_in = {ser_latch, ser_dat, ser_clk};

  ser3_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(raw_in), .sync_out(sync_in)
  );

  ser3_edge #(.W(2)) u_edge (
    .clk(clk), .rst(rst),
    .level({sync_in[I_LAT], sync_in[I_CLK]}),
    .rise(rises)
  );

  ser3_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .en(mode_3w),
    .step(rises[0]), .bit_in(sync_in[I_DAT]),
    .word(word)
  );

  assign cw = ctrl_word_t'(word);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= mode_3w && rises[1];
      if (mode_3w && rises[1]) begin
        wr_addr <= cw.addr;
        wr_data <= cw.data;
      end
    end
  end

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid); // R3
  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !mode_3w |=> !wr_valid); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> ($stable(wr_addr) && $stable(wr_data))); // R9
  AST_COMMIT_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (mode_3w && rises[1]) |=> ({wr_addr, wr_data} == $past(word))); // R1
endmodule

// File: tb/tb_ser3_write_port.sv
`timescale 1ns/1ps
module tb_ser3_write_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_3w = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
  logic       wr_valid;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;

  int checks = 0;
  int errors = 0;
  int send_pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ser3_write_port dut (
    .clk(clk), .rst(rst), .mode_3w(mode_3w),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_latch(ser_latch),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  localparam int NV = 7;
  localparam logic [31:0] VEC_BITS [NV] = '{
    32'h0000_A5C3, 32'h0000_FFFF, 32'h0000_0001, 32'h0003_8000,
    32'hABCD_1234, 32'h0000_01FF, 32'h0000_FE00 };
  localparam int VEC_N [NV] = '{16, 16, 16, 20, 32, 16, 16};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk) if (wr_valid) send_pulses++;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
      wait_cyc(4);
    end
  endtask

  task automatic latch_word(output int np, output int cnt_fall,
                            output logic [6:0] a, output logic [8:0] d);
    np = 0; cnt_fall = 0; a = wr_addr; d = wr_data;
    ser_latch = 1'b1;
    repeat (10) @(negedge clk) if (wr_valid) begin np++; a = wr_addr; d = wr_data; end
    ser_latch = 1'b0;
    repeat (10) @(negedge clk) if (wr_valid) cnt_fall++;
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int np, nf;
    logic [6:0] a;
    logic [8:0] d;
    logic [15:0] w;

    repeat (3) @(negedge clk);
    chk(wr_valid == 0 && wr_addr == 0 && wr_data == 0, "R8 reset outputs",
        {wr_valid, wr_addr, wr_data}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R5: short word after reset, zeros above
    send_bits(32'h16, 5);
    latch_word(np, nf, a, d);
    chk(np == 1, "R3 short word pulse", np, 1);
    chk({a, d} == 16'h0016, "R5 short word value", {a, d}, 16'h0016);

    // Vector table: R1, R2, R3, R4, R6
    for (int k = 0; k < NV; k++) begin
      w = VEC_BITS[k][15:0];
      send_bits(VEC_BITS[k], VEC_N[k]);
      latch_word(np, nf, a, d);
      chk(np == 1, "R3 one pulse per latch", np, 1);
      chk(nf == 0, "R6 no pulse on latch fall", nf, 0);
      chk(a == w[15:9], (VEC_N[k] > 16) ? "R4 address last 16" : "R1 address", a, w[15:9]);
      chk(d == w[8:0], (VEC_N[k] > 16) ? "R4 data last 16" : "R1 data", d, w[8:0]);
    end

    // R6: shifting while latch held high makes no pulse
    ser_latch = 1'b1;
    wait_cyc(10);
    send_pulses = 0;
    send_bits(32'h1357, 16);
    chk(send_pulses == 0, "R6 latch held high", send_pulses, 0);
    ser_latch = 1'b0;
    wait_cyc(10);
    chk(send_pulses == 0, "R6 latch falling", send_pulses, 0);

    // R9: outputs hold while shifting without latch
    latch_word(np, nf, a, d);
    send_pulses = 0;
    send_bits(32'hC3A5, 16);
    chk(send_pulses == 0 && wr_addr == a && wr_data == d, "R9 outputs hold",
        {wr_addr, wr_data}, {a, d});
    latch_word(np, nf, a, d);
    chk({a, d} == 16'hC3A5, "R2 one bit per rising edge", {a, d}, 16'hC3A5);

    // R7: port off ignores latch and clears shift register
    send_bits(32'hFFFF, 16);
    mode_3w = 1'b0;
    wait_cyc(4);
    send_pulses = 0;
    send_bits(32'hF0F0, 16);
    latch_word(np, nf, a, d);
    chk(np == 0 && send_pulses == 0, "R7 no write when off", np, 0);
    mode_3w = 1'b1;
    wait_cyc(4);
    send_bits(32'h5, 3);
    latch_word(np, nf, a, d);
    chk(np == 1 && {a, d} == 16'h0005, "R7 shift cleared while off", {a, d}, 16'h0005);

    // R8: reset mid-stream clears outputs and shift register
    send_bits(32'hFFFF, 16);
    do_reset();
    chk(wr_valid == 0 && wr_addr == 0 && wr_data == 0, "R8 reset clears outputs",
        {wr_addr, wr_data}, 0);
    send_bits(32'h3, 2);
    latch_word(np, nf, a, d);
    chk({a, d} == 16'h0003, "R8 reset clears shift", {a, d}, 16'h0003);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule